// File: doc/BRIEF.md
# Speculative Load Alias Guard Table

This block tracks loads that a static scheduler has moved above earlier stores whose addresses were not known to differ. When such an early load issues, the block records the load's destination register tag together with the byte range the load read. Every store then snoops the table and cancels each record whose byte range overlaps the store's bytes. When the load's original position in program order is reached, a check operation presents the register tag. The block answers whether the record is still alive. A live record means the early value is safe to use. A dead or missing record means the caller must branch to recovery code that reloads the value.

The table is fully associative and has a parameterised number of slots (16 by default). Each slot holds a valid flag, a register tag, a base address and an access size. The table never needs to hold every record. If a record is lost through eviction, a later check fails and the reload runs. A stale value can never be accepted this way. Checks return their verdict one cycle after they are presented. A check may also release its slot.

Top module: `spec_load_guard`

## Requirements
- R1: After synchronous reset every slot is empty, ck_done is low, and any check reports failure.
- R2: After a load is recorded with tag T, a check of T with no overlapping store in between reports ck_ok = 1.
- R3: A check of a tag that has no live record reports ck_ok = 0.
- R4: Access size is encoded as 2^size bytes (size 0 to 3 give 1, 2, 4 and 8 bytes). A store kills a record when their byte ranges [addr, addr + 2^size) overlap, including a partial overlap of one byte. A store whose range only touches the record's range, without sharing a byte, leaves the record alive.
- R5: A single store kills every record it overlaps in the same cycle, and leaves non-overlapping records alive.
- R6: Recording a load whose tag already has a live record replaces that record in its slot. From then on, only stores that overlap the new range kill it.
- R7: While a free slot exists, a new tag takes the lowest-numbered free slot. A full table of distinct tags keeps all records alive.
- R8: When the table is full and the tag is new, the slot named by a round-robin pointer is overwritten. The pointer starts at slot 0 after reset and advances by one on each eviction. The evicted tag's later check fails.
- R9: When a record and an overlapping store arrive in the same cycle, the store counts as older, and the new record stays alive.
- R10: When a check and an overlapping store arrive in the same cycle, the store counts as older, and the check reports failure.
- R11: A check with ck_clear = 0 leaves the record alive. A check with ck_clear = 1 reports its verdict and then frees the slot, so a repeat check fails.
- R12: ck_done is high in exactly the cycle after ck_valid was sampled. ck_ok is low whenever ck_done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Record a speculative load this cycle |
| ld_tag | input | TAG_W | Destination register tag of the load |
| ld_addr | input | ADDR_W | Base byte address of the load |
| ld_size | input | 2 | Load size code, 2^size bytes |
| st_valid | input | 1 | A store is snooped this cycle |
| st_addr | input | ADDR_W | Base byte address of the store |
| st_size | input | 2 | Store size code, 2^size bytes |
| ck_valid | input | 1 | Check a tag this cycle |
| ck_tag | input | TAG_W | Register tag being checked |
| ck_clear | input | 1 | Free the slot after this check |
| ck_done | output | 1 | Check verdict valid (one cycle after ck_valid) |
| ck_ok | output | 1 | 1: speculative value safe; 0: recovery needed |

## Verification
A store can arrive in the same cycle as a new record, or in the same cycle as a check, and in both cases the store must be ordered before the other operation. The bench drives each pairing on one clock edge with an overlapping store range. It then judges the outcome only at the ports. After the store-plus-record cycle, a following check must pass. The check issued together with the store must itself fail, and so must a repeat check. A clearing check and a normal check of the same tag are also run one after another, to show which one keeps the record.

// File: rtl/slg_pkg.sv
package slg_pkg;

    // Access size code: number of bytes is 2**code
    typedef enum logic [1:0] {
        SZ_B1 = 2'd0,
        SZ_B2 = 2'd1,
        SZ_B4 = 2'd2,
        SZ_B8 = 2'd3
    } acc_size_e;

    localparam int SIZE_W = 2;

    function automatic logic [3:0] span_bytes(acc_size_e s);
        return 4'd1 << s;
    endfunction

endpackage

// File: rtl/slg_slot.sv
module slg_slot
    import slg_pkg::*;
#(
    parameter int TAG_W  = 7,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_addr,
    input  acc_size_e         wr_size,
    input  logic              kill,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  acc_size_e         st_size,
    input  logic [TAG_W-1:0]  ins_tag,
    input  logic [TAG_W-1:0]  chk_tag,
    output logic              occupied,
    output logic              ins_match,
    output logic              chk_match,
    output logic              st_hit
);
    localparam int EXT_W = ADDR_W + 1;

    typedef struct packed {
        logic              live;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] base;
        acc_size_e         size;
    } slot_t;

    slot_t cur;

    function automatic logic [EXT_W-1:0] range_end(logic [ADDR_W-1:0] a, acc_size_e s);
        return {1'b0, a} + {{(EXT_W-4){1'b0}}, span_bytes(s)};
    endfunction

    logic [EXT_W-1:0] rec_lo, rec_hi, st_lo, st_hi;

    always_comb begin
        rec_lo = {1'b0, cur.base};
        rec_hi = range_end(cur.base, cur.size);
        st_lo  = {1'b0, st_addr};
        st_hi  = range_end(st_addr, st_size);
    end

    assign occupied  = cur.live;
    assign ins_match = cur.live && (cur.tag == ins_tag);
    assign chk_match = cur.live && (cur.tag == chk_tag);
    assign st_hit    = cur.live && st_valid && (rec_lo < st_hi) && (st_lo < rec_hi);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '{live: 1'b0, tag: '0, base: '0, size: SZ_B1};
        end else if (wr_en) begin
            // store of the same cycle is older: the new record survives
            cur <= '{live: 1'b1, tag: wr_tag, base: wr_addr, size: wr_size};
        end else if (st_hit || kill) begin
            cur.live <= 1'b0;
        end
    end

    a_r9_insert_survives: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> occupied);

    a_r4_overlap_kills: assert property (@(posedge clk) disable iff (rst)
        (st_hit && !wr_en) |=> !occupied);

    a_r11_clear_frees: assert property (@(posedge clk) disable iff (rst)
        (kill && !wr_en) |=> !occupied);

endmodule

// File: rtl/slg_alloc.sv
module slg_alloc #(
    parameter int ENTRIES = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ins_valid,
    input  logic [ENTRIES-1:0] occ_vec,
    input  logic [ENTRIES-1:0] tag_hit_vec,
    output logic [ENTRIES-1:0] wr_vec
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0]   rr_ptr;
    logic [ENTRIES-1:0] free_vec, first_free, victim;
    logic               any_hit, full, evict;

    always_comb begin
        free_vec   = ~occ_vec;
        first_free = free_vec & (~free_vec + ENTRIES'(1));
        victim     = ENTRIES'(1) << rr_ptr;
        any_hit    = |tag_hit_vec;
        full       = &occ_vec;
        evict      = ins_valid && !any_hit && full;
        if (!ins_valid)   wr_vec = '0;
        else if (any_hit) wr_vec = tag_hit_vec;
        else if (!full)   wr_vec = first_free;
        else              wr_vec = victim;
    end

    always_ff @(posedge clk) begin
        if (rst)        rr_ptr <= '0;
        else if (evict) rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
    end

    a_r7_one_target: assert property (@(posedge clk) disable iff (rst)
        ins_valid |-> $countones(wr_vec) == 1);

    a_r8_pointer_steps: assert property (@(posedge clk) disable iff (rst)
        evict |=> rr_ptr != $past(rr_ptr));

    a_r8_pointer_holds: assert property (@(posedge clk) disable iff (rst)
        !evict |=> $stable(rr_ptr));

endmodule

// File: rtl/slg_verdict.sv
module slg_verdict #(
    parameter int ENTRIES = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               chk_valid,
    input  logic               chk_clear,
    input  logic [ENTRIES-1:0] chk_match_vec,
    input  logic [ENTRIES-1:0] st_hit_vec,
    output logic [ENTRIES-1:0] kill_vec,
    output logic               chk_done,
    output logic               chk_ok
);
    logic alive_now;

    // a store in the same cycle is older than the check
    assign alive_now = |(chk_match_vec & ~st_hit_vec);
    assign kill_vec  = (chk_valid && chk_clear) ? chk_match_vec : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_done <= 1'b0;
            chk_ok   <= 1'b0;
        end else begin
            chk_done <= chk_valid;
            chk_ok   <= chk_valid && alive_now;
        end
    end

    a_r12_done_follows: assert property (@(posedge clk) disable iff (rst)
        chk_valid |=> chk_done);

    a_r12_ok_quiet: assert property (@(posedge clk) disable iff (rst)
        !chk_done |-> !chk_ok);

    a_r10_store_first: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && |(chk_match_vec & st_hit_vec)) |=> !chk_ok);

    a_r3_absent_fails: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && !(|chk_match_vec)) |=> !chk_ok);

endmodule

// File: rtl/spec_load_guard.sv
module spec_load_guard
    import slg_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 7,
    parameter int ADDR_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [1:0]        ld_size,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [1:0]        st_size,
    input  logic              ck_valid,
    input  logic [TAG_W-1:0]  ck_tag,
    input  logic              ck_clear,
    output logic              ck_done,
    output logic              ck_ok
);
    logic [ENTRIES-1:0] occ_vec, ins_hit_vec, chk_hit_vec, st_hit_vec;
    logic [ENTRIES-1:0] wr_vec, kill_vec;
    acc_size_e          ld_sz, st_sz;

    assign ld_sz = acc_size_e'(ld_size);
    assign st_sz = acc_size_e'(st_size);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        slg_slot #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) slot_i (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_vec[i]),
            .wr_tag   (ld_tag),
            .wr_addr  (ld_addr),
            .wr_size  (ld_sz),
            .kill     (kill_vec[i]),
            .st_valid (st_valid),
            .st_addr  (st_addr),
            .st_size  (st_sz),
            .ins_tag  (ld_tag),
            .chk_tag  (ck_tag),
            .occupied (occ_vec[i]),
            .ins_match(ins_hit_vec[i]),
            .chk_match(chk_hit_vec[i]),
            .st_hit   (st_hit_vec[i])
        );
    end

    slg_alloc #(.ENTRIES(ENTRIES)) alloc_i (
        .clk        (clk),
        .rst        (rst),
        .ins_valid  (ld_valid),
        .occ_vec    (occ_vec),
        .tag_hit_vec(ins_hit_vec),
        .wr_vec     (wr_vec)
    );

    slg_verdict #(.ENTRIES(ENTRIES)) verdict_i (
        .clk          (clk),
        .rst          (rst),
        .chk_valid    (ck_valid),
        .chk_clear    (ck_clear),
        .chk_match_vec(chk_hit_vec),
        .st_hit_vec   (st_hit_vec),
        .kill_vec     (kill_vec),
        .chk_done     (ck_done),
        .chk_ok       (ck_ok)
    );

    a_r6_unique_tag: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ins_hit_vec));

    a_r6_unique_check: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chk_hit_vec));

    a_r1_empty_after_reset: assert property (@(posedge clk)
        $past(rst) |-> occ_vec == '0);

endmodule

// File: tb/spec_load_guard_tb.sv
`timescale 1ns/1ps
module spec_load_guard_tb_top;
    localparam int TAG_W  = 7;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst;
    logic              ld_valid, st_valid, ck_valid, ck_clear;
    logic [TAG_W-1:0]  ld_tag, ck_tag;
    logic [ADDR_W-1:0] ld_addr, st_addr;
    logic [1:0]        ld_size, st_size;
    logic              ck_done, ck_ok;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 0;
    bit    exp_q[$];
    string req_q[$];

    always #4 clk = ~clk;

    spec_load_guard dut_i (
        .clk(clk), .rst(rst),
        .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_addr(ld_addr), .ld_size(ld_size),
        .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
        .ck_valid(ck_valid), .ck_tag(ck_tag), .ck_clear(ck_clear),
        .ck_done(ck_done), .ck_ok(ck_ok)
    );

    task automatic idle_inputs();
        ld_valid = 0; st_valid = 0; ck_valid = 0; ck_clear = 0;
        ld_tag = '0; ck_tag = '0; ld_addr = '0; st_addr = '0; ld_size = '0; st_size = '0;
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic put_load(input int tag, input int addr, input int sz);
        ld_valid = 1; ld_tag = TAG_W'(tag); ld_addr = ADDR_W'(addr); ld_size = 2'(sz);
    endtask

    task automatic put_store(input int addr, input int sz);
        st_valid = 1; st_addr = ADDR_W'(addr); st_size = 2'(sz);
    endtask

    // driver: presents a check and pushes the expected verdict to the scoreboard
    task automatic put_check(input int tag, input bit clr, input bit exp, input string req);
        ck_valid = 1; ck_tag = TAG_W'(tag); ck_clear = clr;
        exp_q.push_back(exp);
        req_q.push_back(req);
    endtask

    task automatic do_load(input int tag, input int addr, input int sz);
        put_load(tag, addr, sz); cycle();
    endtask

    task automatic do_store(input int addr, input int sz);
        put_store(addr, sz); cycle();
    endtask

    task automatic do_check(input int tag, input bit clr, input bit exp, input string req);
        put_check(tag, clr, exp, req); cycle();
    endtask

    // monitor: compares verdicts as they appear
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst) continue;
            if (exp_q.size() > 0) begin
                bit    e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                n_checks++;
                if (ck_done !== 1'b1 || ck_ok !== e) begin
                    n_fail++;
                    $display("FAIL %s: done=%b ok=%b expected done=1 ok=%b", r, ck_done, ck_ok, e);
                end
            end else if (ck_done !== 1'b0 || ck_ok !== 1'b0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R12: done=%b ok=%b expected done=0 ok=0", ck_done, ck_ok);
            end
        end
    end

    task automatic do_reset();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    initial begin
        idle_inputs();
        @(negedge clk);
        do_reset();
        // R1: reset state at the ports
        n_checks++;
        if (ck_done !== 1'b0 || ck_ok !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: done=%b ok=%b expected done=0 ok=0", ck_done, ck_ok);
        end
        do_check(5, 0, 0, "R1");

        // R2, R3
        do_load(3, 'h100, 3);
        do_check(3, 0, 1, "R2");
        do_check(4, 0, 0, "R3");

        // R11: plain check keeps, clearing check frees
        do_check(3, 0, 1, "R11");
        do_check(3, 1, 1, "R11");
        do_check(3, 0, 0, "R11");

        // R4: touching ranges survive, overlaps kill
        do_load(10, 'h200, 2);
        do_store('h204, 2);
        do_check(10, 0, 1, "R4");
        do_store('h1FC, 2);
        do_check(10, 0, 1, "R4");
        do_store('h203, 0);
        do_check(10, 0, 0, "R4");
        do_load(11, 'h300, 1);
        do_store('h2FC, 3);
        do_check(11, 0, 0, "R4");

        // R5: one store kills several records
        do_load(20, 'h400, 0);
        do_load(21, 'h402, 1);
        do_load(22, 'h500, 2);
        do_store('h400, 3);
        do_check(20, 0, 0, "R5");
        do_check(21, 0, 0, "R5");
        do_check(22, 0, 1, "R5");

        // R6: same tag replaces the record
        do_load(30, 'h600, 2);
        do_load(30, 'h700, 2);
        do_store('h600, 2);
        do_check(30, 0, 1, "R6");
        do_store('h700, 2);
        do_check(30, 0, 0, "R6");

        // R9: record and overlapping store in one cycle
        put_load(40, 'h800, 2);
        put_store('h800, 2);
        cycle();
        do_check(40, 0, 1, "R9");

        // R10: check and overlapping store in one cycle
        do_load(41, 'h900, 2);
        put_check(41, 0, 0, "R10");
        put_store('h900, 2);
        cycle();
        do_check(41, 0, 0, "R10");

        // R7, R8: fill, then round-robin eviction
        do_reset();
        do_check(55, 0, 0, "R1");
        for (int i = 0; i < 16; i++) do_load(50 + i, 'h1000 + 16 * i, 2);
        for (int i = 0; i < 16; i++) do_check(50 + i, 0, 1, "R7");
        do_load(66, 'h2000, 2);
        do_check(50, 0, 0, "R8");
        do_check(51, 0, 1, "R8");
        do_check(66, 0, 1, "R8");
        do_load(67, 'h2100, 2);
        do_check(51, 0, 0, "R8");
        do_check(52, 0, 1, "R8");
        do_check(67, 0, 1, "R8");

        repeat (3) cycle();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule